// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

This block is a 16-bit up/down counter behind a small synchronous register port. It runs one of four counting functions. In the plain function it counts an internal tick that comes from a programmable divider. In the three decoding functions it turns the edges of two pre-synchronised encoder phases, A and B, into up and down steps. The count moves between zero and a programmable ceiling and wraps at either end. Every wrap, and every update command from software, produces an update event. The event shows for one cycle on an output pulse.

Software loads the counting function, the ceiling, the divider ratio and the control bits by writing registers. It can also overwrite the count. It reads the count, the direction of the last step and the stored settings back on a separate combinational read port. The divider ratio is always double-buffered: a written value becomes active at the next update event. The ceiling is double-buffered only while the buffering control bit is set.

Top module: `qenc_timer`

## Requirements
- R1: After reset the count is 0, the active and stored ceilings are all ones, the divider value is 0 (ratio 1), counting is off, buffering is off, the function code is 0, the direction bit is 0 and the update pulse is low.
- R2: With function code 0 (register address 1, bits [2:0]) and the run bit set (address 0, bit 0), the count rises by one on each divider tick. Encoder inputs have no effect in this function. With the run bit clear, the count holds in every function.
- R3: The divider register (address 4) holds ratio minus one, so a value N gives one tick every N+1 cycles. A written value becomes active only at the next update event, and every update event restarts the division from zero.
- R4: Function code 1 steps on each edge of A: up when A and B differ after the edge, down when they are equal. Edges of B alone do not step.
- R5: Function code 2 steps on each edge of B: up when A and B are equal after the edge, down when they differ. Edges of A alone do not step.
- R6: Function code 3 steps on edges of either input, using the R4 rule for A and the R5 rule for B. A cycle in which both inputs change gives no step. Codes 4 to 7 hold the count.
- R7: An up step from a count at or above the active ceiling gives 0. A down step from 0 gives the active ceiling. Either wrap raises the update pulse in the cycle where the wrapped count first reads back.
- R8: A count write (address 2) above the active ceiling is ignored and does not block a step in that cycle. An accepted write replaces the count and suppresses that cycle's step.
- R9: With the buffering bit (address 0, bit 1) clear, a ceiling write (address 3) becomes active at once. With it set, the value is stored and becomes active at the next update event. Reads of address 3 return the stored value.
- R10: Writing 1 to bit 0 of address 5 forces an update event: the count becomes 0, the pulse is raised, and the stored divider and (if buffering) the stored ceiling become active. This command takes priority over a count write and over a step.
- R11: Bit 4 of address 0 reads 1 after a down step and 0 after an up step. It holds its value until the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| enc_a | input | 1 | Encoder phase A, already synchronised |
| enc_b | input | 1 | Encoder phase B, already synchronised |
| upd_pulse | output | 1 | One-cycle update event marker |

## Verification
The bench builds the block with its default 16-bit count, divider and data widths. At run time it programs a ceiling of 5 and then 3, which makes wraps in both directions and buffered ceiling transfers reachable within a few dozen cycles. A divider value of 2 makes the delayed transfer, and the restart of the division on an update command, visible in the tick spacing. A random stretch over the four counting functions tests the edge and direction rules against a behavioural model on every cycle.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned MODE_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] A_CEIL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PSC   = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMD   = 3'd5;

    localparam logic [MODE_W-1:0] MODE_PLAIN = 3'd0;
    localparam logic [MODE_W-1:0] MODE_X2A   = 3'd1;
    localparam logic [MODE_W-1:0] MODE_X2B   = 3'd2;
    localparam logic [MODE_W-1:0] MODE_X4    = 3'd3;
endpackage

// File: rtl/qenc_edge_decode.sv
module qenc_edge_decode
    import qenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_i,
    input  logic              b_i,
    input  logic              en_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              up_o,
    output logic              dn_o
);
    logic pa_q, pb_q, pa_d, pb_d;
    logic edge_a, edge_b, a_fwd, b_fwd;

    always_comb begin
        pa_d   = a_i;
        pb_d   = b_i;
        edge_a = a_i ^ pa_q;
        edge_b = b_i ^ pb_q;
        a_fwd  = a_i ^ b_i;
        b_fwd  = ~(a_i ^ b_i);
        up_o   = 1'b0;
        dn_o   = 1'b0;
        if (en_i) begin
            case (mode_i)
                MODE_X2A: if (edge_a) begin
                    up_o = a_fwd;
                    dn_o = ~a_fwd;
                end
                MODE_X2B: if (edge_b) begin
                    up_o = b_fwd;
                    dn_o = ~b_fwd;
                end
                MODE_X4: begin
                    if (edge_a && !edge_b) begin
                        up_o = a_fwd;
                        dn_o = ~a_fwd;
                    end else if (edge_b && !edge_a) begin
                        up_o = b_fwd;
                        dn_o = ~b_fwd;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa_q <= 1'b0;
            pb_q <= 1'b0;
        end else begin
            pa_q <= pa_d;
            pb_q <= pb_d;
        end
    end

    AST_STEP_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o || dn_o) |-> (a_i != pa_q || b_i != pb_q)); // R4
    AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up_o, dn_o})); // R6
endmodule

// File: rtl/qenc_prescaler.sv
module qenc_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] ratio_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] div_q, div_d;

    always_comb begin
        tick_o = en_i && (div_q == ratio_i);
        div_d  = div_q;
        if (restart_i)
            div_d = '0;
        else if (en_i)
            div_d = tick_o ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && ratio_i != '0 && !restart_i) |=> !tick_o); // R3
endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
    import qenc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              enc_a,
    input  logic              enc_b,
    output logic              upd_pulse
);
    localparam logic [CNT_W-1:0] CEIL_RST = {CNT_W{1'b1}};
    localparam int unsigned DIR_BIT = 4;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  ceil_act;
        logic [CNT_W-1:0]  ceil_shd;
        logic [PSC_W-1:0]  psc_act;
        logic [PSC_W-1:0]  psc_shd;
        logic [MODE_W-1:0] mode;
        logic              run;
        logic              pre;
        logic              dir;
        logic              upd;
    } state_t;

    state_t st_q, st_d;
    logic   tick, enc_up, enc_dn, step_up, step_dn, ev;
    logic   wr_cnt, cnt_ok, sw_upd;

    qenc_edge_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (enc_a),
        .b_i    (enc_b),
        .en_i   (st_q.run),
        .mode_i (st_q.mode),
        .up_o   (enc_up),
        .dn_o   (enc_dn)
    );

    qenc_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (st_q.run && st_q.mode == MODE_PLAIN),
        .restart_i (ev),
        .ratio_i   (st_q.psc_act),
        .tick_o    (tick)
    );

    always_comb begin
        st_d    = st_q;
        ev      = 1'b0;
        sw_upd  = wr_en && wr_addr == A_CMD && wr_data[0];
        wr_cnt  = wr_en && wr_addr == A_COUNT;
        cnt_ok  = wr_cnt && (wr_data[CNT_W-1:0] <= st_q.ceil_act);
        step_up = tick || enc_up;
        step_dn = enc_dn;

        if (sw_upd) begin
            st_d.cnt = '0;
            ev       = 1'b1;
        end else if (cnt_ok) begin
            st_d.cnt = wr_data[CNT_W-1:0];
        end else if (step_up) begin
            st_d.dir = 1'b0;
            if (st_q.cnt >= st_q.ceil_act) begin
                st_d.cnt = '0;
                ev       = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (step_dn) begin
            st_d.dir = 1'b1;
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.ceil_act;
                ev       = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    st_d.run = wr_data[0];
                    st_d.pre = wr_data[1];
                end
                A_MODE: st_d.mode = wr_data[MODE_W-1:0];
                A_CEIL: begin
                    st_d.ceil_shd = wr_data[CNT_W-1:0];
                    if (!st_q.pre) st_d.ceil_act = wr_data[CNT_W-1:0];
                end
                A_PSC:  st_d.psc_shd = wr_data[PSC_W-1:0];
                default: ;
            endcase
        end

        if (ev) begin
            st_d.psc_act = st_q.psc_shd;
            if (st_q.pre) st_d.ceil_act = st_q.ceil_shd;
        end
        st_d.upd = ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ceil_act <= CEIL_RST;
            st_q.ceil_shd <= CEIL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[0]       = st_q.run;
                rd_data[1]       = st_q.pre;
                rd_data[DIR_BIT] = st_q.dir;
            end
            A_MODE:  rd_data[MODE_W-1:0] = st_q.mode;
            A_COUNT: rd_data[CNT_W-1:0]  = st_q.cnt;
            A_CEIL:  rd_data[CNT_W-1:0]  = st_q.ceil_shd;
            A_PSC:   rd_data[PSC_W-1:0]  = st_q.psc_shd;
            default: ;
        endcase
    end

    assign upd_pulse = st_q.upd;

    AST_SWUPD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_upd |=> (st_q.cnt == '0 && upd_pulse)); // R10
    AST_BAD_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && wr_data[CNT_W-1:0] > st_q.ceil_act && !sw_upd && !step_up && !step_dn)
        |=> $stable(st_q.cnt)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !sw_upd && !wr_cnt) |=> $stable(st_q.cnt)); // R2
    AST_PLAIN_NO_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.mode == MODE_PLAIN && !tick && !sw_upd && !wr_cnt)
        |=> $stable(st_q.cnt)); // R2
    AST_DIR_AFTER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_dn && !step_up && !sw_upd && !cnt_ok) |=> st_q.dir); // R11
endmodule

// File: tb/qenc_timer_bench.sv
`timescale 1ns/1ps
module qenc_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd2;
    logic [15:0] rd_data;
    logic        enc_a = 1'b0;
    logic        enc_b = 1'b0;
    logic        upd_pulse;

    int vectors = 0;
    int miscompares = 0;
    int wd = 0;
    bit done = 0;
    string cur_req = "R1";
    int rd_idx = 0;
    int rd_seq [6] = '{2, 0, 2, 3, 2, 4};
    bit cur_a = 0, cur_b = 0;

    // behavioural reference state
    int m_cnt = 0, m_ceila = 65535, m_ceils = 65535, m_psca = 0, m_pscs = 0;
    int m_div = 0, m_mode = 0;
    bit m_run = 0, m_pre = 0, m_dir = 0, m_upd = 0, m_pa = 0, m_pb = 0;

    always #2 clk = ~clk;

    qenc_timer u_qenc_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .enc_a(enc_a), .enc_b(enc_b), .upd_pulse(upd_pulse)
    );

    function automatic int mread(input int ad);
        case (ad)
            0: return (m_dir << 4) | (m_pre << 1) | m_run;
            1: return m_mode;
            2: return m_cnt;
            3: return m_ceils;
            4: return m_pscs;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit ugc, up, dn, ea, eb, ev, tick;
        int n_cnt, wd_i;
        if (!rst_n) begin
            m_cnt = 0; m_ceila = 65535; m_ceils = 65535; m_psca = 0; m_pscs = 0;
            m_div = 0; m_mode = 0; m_run = 0; m_pre = 0; m_dir = 0; m_upd = 0;
            m_pa = 0; m_pb = 0;
        end else begin
            wd_i = int'(wr_data);
            ugc = wr_en && wr_addr == 5 && wr_data[0];
            up = 0; dn = 0; tick = 0; ev = 0;
            ea = (enc_a != m_pa); eb = (enc_b != m_pb);
            if (m_run) begin
                if (m_mode == 0) begin
                    tick = (m_div == m_psca); up = tick;
                end else if (m_mode == 1 || (m_mode == 3 && ea && !eb)) begin
                    if (ea) begin if (enc_a != enc_b) up = 1; else dn = 1; end
                end else if (m_mode == 2 || (m_mode == 3 && eb && !ea)) begin
                    if (eb) begin if (enc_a == enc_b) up = 1; else dn = 1; end
                end
            end
            n_cnt = m_cnt;
            if (ugc) begin n_cnt = 0; ev = 1; end
            else if (wr_en && wr_addr == 2 && wd_i <= m_ceila) n_cnt = wd_i;
            else if (up) begin
                m_dir = 0;
                if (m_cnt >= m_ceila) begin n_cnt = 0; ev = 1; end else n_cnt = m_cnt + 1;
            end else if (dn) begin
                m_dir = 1;
                if (m_cnt == 0) begin n_cnt = m_ceila; ev = 1; end else n_cnt = m_cnt - 1;
            end
            if (ev) m_div = 0;
            else if (m_run && m_mode == 0) m_div = tick ? 0 : (m_div + 1) % 65536;
            if (ev) begin
                m_psca = m_pscs;
                if (m_pre) m_ceila = m_ceils;
            end
            if (wr_en) begin
                case (wr_addr)
                    0: begin m_run = wr_data[0]; m_pre = wr_data[1]; end
                    1: m_mode = wd_i % 8;
                    3: begin m_ceils = wd_i; if (!m_pre) m_ceila = wd_i; end
                    4: m_pscs = wd_i;
                    default: ;
                endcase
            end
            m_cnt = n_cnt; m_upd = ev; m_pa = enc_a; m_pb = enc_b;
        end
    end

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        int exp;
        exp = mread(int'(rd_addr));
        vectors++;
        if (rd_data !== exp[15:0] || upd_pulse !== m_upd) begin
            miscompares++;
            $display("FAIL %s: addr %0d rd_data %h exp %h, pulse %b exp %b",
                     cur_req, rd_addr, rd_data, exp[15:0], upd_pulse, m_upd);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            miscompares++;
            $display("FAIL watchdog: cycles %0d exp below 150000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic cyc(input bit we, input int ad, input int dt, input bit a, input bit b);
        @(negedge clk); #1;
        wr_en = we; wr_addr = ad[2:0]; wr_data = dt[15:0];
        enc_a = a; enc_b = b; cur_a = a; cur_b = b;
        rd_idx = (rd_idx + 1) % 6; rd_addr = rd_seq[rd_idx][2:0];
    endtask
    task automatic wr(input int ad, input int dt);
        cyc(1, ad, dt, cur_a, cur_b);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, cur_a, cur_b);
    endtask
    task automatic enc(input bit a, input bit b);
        cyc(0, 0, 0, a, b); idle(1);
    endtask
    task automatic fwd(input int n);
        for (int i = 0; i < n; i++) begin enc(1,0); enc(1,1); enc(0,1); enc(0,0); end
    endtask
    task automatic bwd(input int n);
        for (int i = 0; i < n; i++) begin enc(0,1); enc(1,1); enc(1,0); enc(0,0); end
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(6);
        // R2: plain counting ignores encoder; hold when stopped
        cur_req = "R2";
        wr(0, 1);
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, i[0], i[1]);
        cyc(0, 0, 0, 0, 0);
        // R3: buffered divider, restart on update command
        cur_req = "R3";
        wr(4, 2); idle(7);
        cur_req = "R10";
        wr(5, 1); idle(2);
        cur_req = "R3";
        idle(14);
        cur_req = "R2";
        wr(0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, i[0], i[2]);
        cyc(0, 0, 0, 0, 0);
        // R4 R11: x2 on A
        cur_req = "R4,R11";
        wr(1, 1); wr(0, 1); fwd(3); bwd(2);
        cur_req = "R5,R11";
        wr(1, 2); fwd(3); bwd(4);
        cur_req = "R6";
        wr(1, 3); fwd(2); bwd(1);
        enc(1, 1); enc(0, 0);
        wr(1, 5); fwd(2);
        // R7 R9: immediate ceiling, wrap both ways
        cur_req = "R9";
        wr(3, 5); wr(4, 0);
        cur_req = "R10";
        wr(5, 1);
        cur_req = "R7";
        wr(1, 0); idle(16);
        wr(1, 3); wr(2, 1); bwd(3);
        // R9: buffered ceiling held until update event
        cur_req = "R9";
        wr(0, 3); wr(3, 3); wr(1, 0); idle(16);
        // R8: count writes against the ceiling
        cur_req = "R8";
        wr(0, 2); wr(2, 9); idle(3); wr(2, 2); idle(3);
        wr(0, 3); wr(1, 1); wr(2, 7);
        cyc(1, 2, 1, 1, 0); idle(3);
        // random mix of functions and encoder activity
        cur_req = "R4,R5,R6,R7";
        for (int k = 0; k < 8; k++) begin
            wr(1, k % 4);
            for (int i = 0; i < 50; i++) cyc(0, 0, 0, $urandom_range(0,1), $urandom_range(0,1));
        end
        idle(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule